// File: doc/BRIEF.md
# Constant-Time Cyclic Vector Rotator

This block holds an R-bit vector as a set of W-bit words and rotates it right by a secret amount between 0 and R-1. The length R need not be a multiple of W, and the rotation wraps at R exactly. Software-side logic writes the vector one word at a time through a load port. It then pulses `start` with the amount and waits for the `done` pulse. After that it reads the rotated words back through a combinational read port.

Rotation happens in two phases. First, a chain of word-granular barrel layers moves whole words by floor(amount/W). Layer k moves by 2^k words and is applied on every operation through a mask taken from bit k of the word count. Second, a sub-word phase moves each result word by amount mod W, taking bits from the next word up. At start, the vector is copied into a duplicated working register, so bits past position R-1 fold back to position 0. Every amount goes through the same sequence of register updates, so the cycle count never depends on the amount.

Top module: `cyclic_rotator`

## Requirements
- R1: After reset, `done` is low and every word on the read port is zero.
- R2: While `loadEn` is high, the clock edge writes `loadData` into word `loadAddr`. Word j holds vector bits j*W to j*W+W-1, with the LSB of the word at the lowest position. Data bits that fall at vector positions R or above are discarded, and a `loadAddr` of ceil(R/W) or more writes nothing.
- R3: After a rotation by `amount` (0 to R-1), result bit i equals stored bit (i+amount) mod R for every i below R. This is a right rotation. The result uses the same word layout as R2.
- R4: `done` is high for exactly one cycle. It rises NL+1 clock edges after the edge that accepted `start`, for every amount, where NL = max(1, ceil(log2(floor((R-1)/W)+1))). This is 4 edges for R=100, W=16.
- R5: Result bits at positions R and above in the last word always read zero.
- R6: A `start` raised while a rotation is in progress is ignored. The running rotation keeps its amount and its completion cycle.
- R7: The vector is captured on the edge that accepts `start`. Loads made during a rotation do not change its result, and they are used by the next rotation.
- R8: `readData` follows `readAddr` in the same cycle and returns zero for an address of ceil(R/W) or more. The result holds until the next `done`.
- R9: A new `start` is accepted in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write strobe for the stored vector |
| loadAddr | input | ADDR_W | Word index to write |
| loadData | input | WORD_W | Word data to write |
| start | input | 1 | Begin a rotation when idle |
| amount | input | AMT_W | Right rotation distance, below ROT_LEN |
| done | output | 1 | One-cycle pulse when the result is ready |
| readAddr | input | ADDR_W | Word index of the result to read |
| readData | output | WORD_W | Result word, combinational from readAddr |

## Verification
A write lands on the load edge. The bench reads it back only after a later rotation, never in the same cycle. The `done` pulse must be seen at the falling edge after the fourth rising edge that follows the accepting edge. The bench counts falling edges from that accepting edge and compares the count with the latency formula for every amount. Result words are combinational from the read address, so they are sampled a short delay after the address changes, in the low phase of the clock, once `done` has been seen. Ignored stimuli (a second `start` mid-run, loads mid-run, out-of-range addresses) are judged only by the timing of the following `done` pulse and by the words read after it.

// File: rtl/crot_pkg.sv
package crot_pkg;

  // Strobes sent from the sequencer to the datapath each cycle.
  typedef struct packed {
    logic       capture;   // latch amount and duplicated vector
    logic       layerEn;   // apply one barrel layer
    logic [4:0] layerIdx;  // which barrel layer this cycle
    logic       subEn;     // apply the sub-word shift and store result
  } crot_strobe_t;

endpackage

// File: rtl/crot_ctrl.sv
module crot_ctrl
  import crot_pkg::*;
#(
  parameter int NUM_LAYERS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output crot_strobe_t strobe,
  output logic         done
);

  localparam int LCW = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LAYER, S_SUB} seqState_t;

  seqState_t      state;
  seqState_t      stateNext;
  logic [LCW-1:0] layerCnt;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext      = S_LAYER;
        end
      end
      S_LAYER: begin
        strobe.layerEn  = 1'b1;
        strobe.layerIdx = 5'(layerCnt);
        if (layerCnt == LCW'(NUM_LAYERS - 1)) stateNext = S_SUB;
      end
      S_SUB: begin
        strobe.subEn = 1'b1;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      layerCnt <= '0;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture)      layerCnt <= '0;
      else if (strobe.layerEn) layerCnt <= layerCnt + 1'b1;
      done <= strobe.subEn;
    end
  end

  // Edge counter since the accepting edge, used only by the latency check.
  logic [7:0] latCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    latCnt <= '0;
    else if (strobe.capture)      latCnt <= 8'd1;
    else if (latCnt != 8'd0 && latCnt != 8'hFF) latCnt <= latCnt + 8'd1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> latCnt == 8'(NUM_LAYERS + 2));  // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.layerEn, strobe.subEn}));  // R6
  AST_RESTART_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |-> strobe.capture);  // R9

endmodule

// File: rtl/crot_datapath.sv
module crot_datapath
  import crot_pkg::*;
#(
  parameter int ROT_LEN    = 100,
  parameter int WORD_W     = 16,
  parameter int NUM_WORDS  = 7,
  parameter int NUM_LAYERS = 3,
  parameter int AMT_W      = 7,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  crot_strobe_t      strobe,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  logic [AMT_W-1:0]  amount,
  input  logic [ADDR_W-1:0] readAddr,
  output logic [WORD_W-1:0] readData
);

  localparam int MAX_WSHIFT = (ROT_LEN - 1) / WORD_W;
  localparam int EXT_WORDS  = MAX_WSHIFT + NUM_WORDS + 1;
  localparam int EXT_W      = EXT_WORDS * WORD_W;
  localparam int RES_W      = NUM_WORDS * WORD_W;
  localparam int SHIFT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  function automatic logic [RES_W-1:0] validMask();
    logic [RES_W-1:0] m;
    for (int i = 0; i < RES_W; i++) m[i] = (i < ROT_LEN);
    return m;
  endfunction
  localparam logic [RES_W-1:0] VALID_MASK = validMask();

  logic [ROT_LEN-1:0]    storeVec;
  logic [EXT_W-1:0]      dupVec;
  logic [EXT_W-1:0]      extVec;
  logic [EXT_W-1:0]      layerOut [NUM_LAYERS];
  logic [EXT_W-1:0]      layerPick;
  logic                  layerTake;
  logic [EXT_W-1:0]      layerMask;
  logic [NUM_LAYERS-1:0] qReg;
  logic [SHIFT_W-1:0]    sReg;
  logic [RES_W-1:0]      subOut;
  logic [RES_W-1:0]      resultVec;

  // Stored vector: only positions below ROT_LEN exist.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeVec <= '0;
    end else if (loadEn) begin
      for (int i = 0; i < ROT_LEN; i++)
        if (loadAddr == ADDR_W'(i / WORD_W)) storeVec[i] <= loadData[i % WORD_W];
    end
  end

  // Duplicated copy so reads past ROT_LEN-1 fold back to bit 0.
  for (genvar i = 0; i < EXT_W; i++) begin : g_dup
    if (i < ROT_LEN) begin : g_lo
      assign dupVec[i] = storeVec[i];
    end else if (i < 2 * ROT_LEN) begin : g_hi
      assign dupVec[i] = storeVec[i - ROT_LEN];
    end else begin : g_pad
      assign dupVec[i] = 1'b0;
    end
  end

  // Barrel layer k moves by 2^k whole words toward bit 0.
  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
    assign layerOut[k] = extVec >> (WORD_W * (2 ** k));
  end

  always_comb begin
    layerPick = extVec;
    layerTake = 1'b0;
    for (int k = 0; k < NUM_LAYERS; k++) begin
      if (strobe.layerIdx == 5'(k)) begin
        layerPick = layerOut[k];
        layerTake = qReg[k];
      end
    end
    layerMask = {EXT_W{layerTake}};
  end

  // Sub-word stage: each word takes its upper bits from the next word up.
  for (genvar j = 0; j < NUM_WORDS; j++) begin : g_sub
    assign subOut[j*WORD_W +: WORD_W] =
      WORD_W'({extVec[(j+1)*WORD_W +: WORD_W], extVec[j*WORD_W +: WORD_W]} >> sReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extVec    <= '0;
      qReg      <= '0;
      sReg      <= '0;
      resultVec <= '0;
    end else begin
      if (strobe.capture) begin
        extVec <= dupVec;
        qReg   <= NUM_LAYERS'(32'(amount) / WORD_W);
        sReg   <= SHIFT_W'(32'(amount) % WORD_W);
      end else if (strobe.layerEn) begin
        extVec <= (layerPick & layerMask) | (extVec & ~layerMask);
      end
      if (strobe.subEn) resultVec <= subOut & VALID_MASK;
    end
  end

  always_comb begin
    readData = '0;
    for (int j = 0; j < NUM_WORDS; j++)
      if (readAddr == ADDR_W'(j)) readData = resultVec[j*WORD_W +: WORD_W];
  end

  // Weight captured at start, used only by the assertions.
  logic [15:0] capWeight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capWeight <= '0;
    else if (strobe.capture) capWeight <= 16'($countones(storeVec));
  end

  AST_AMOUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> 32'(amount) < ROT_LEN);  // R3
  AST_DUP_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> $countones(extVec) == 2 * $countones($past(storeVec)));  // R3
  AST_RESULT_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.subEn |=> 16'($countones(resultVec)) == capWeight);  // R3
  AST_AMOUNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(qReg) && $stable(sReg));  // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.subEn |=> $stable(resultVec));  // R8

endmodule

// File: rtl/cyclic_rotator.sv
module cyclic_rotator
  import crot_pkg::*;
#(
  parameter int ROT_LEN = 100,
  parameter int WORD_W  = 16,
  localparam int NUM_WORDS  = (ROT_LEN + WORD_W - 1) / WORD_W,
  localparam int MAX_WSHIFT = (ROT_LEN - 1) / WORD_W,
  localparam int NUM_LAYERS = (MAX_WSHIFT == 0) ? 1 : $clog2(MAX_WSHIFT + 1),
  localparam int AMT_W      = (ROT_LEN > 1) ? $clog2(ROT_LEN) : 1,
  localparam int ADDR_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  logic              start,
  input  logic [AMT_W-1:0]  amount,
  output logic              done,
  input  logic [ADDR_W-1:0] readAddr,
  output logic [WORD_W-1:0] readData
);

  crot_strobe_t strobe;

  crot_ctrl #(
    .NUM_LAYERS(NUM_LAYERS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  crot_datapath #(
    .ROT_LEN    (ROT_LEN),
    .WORD_W     (WORD_W),
    .NUM_WORDS  (NUM_WORDS),
    .NUM_LAYERS (NUM_LAYERS),
    .AMT_W      (AMT_W),
    .ADDR_W     (ADDR_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .amount   (amount),
    .readAddr (readAddr),
    .readData (readData)
  );

endmodule

// File: tb/cyclic_rotator_test.sv
`timescale 1ns/1ps
module cyclic_rotator_test;

  localparam int R      = 100;
  localparam int W      = 16;
  localparam int NW     = (R + W - 1) / W;
  localparam int QMAX   = (R - 1) / W;
  localparam int NL     = (QMAX == 0) ? 1 : $clog2(QMAX + 1);
  localparam int LAT    = NL + 1;
  localparam int AMT_W  = $clog2(R);
  localparam int ADDR_W = (NW > 1) ? $clog2(NW) : 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [W-1:0]      loadData = '0;
  logic              start = 1'b0;
  logic [AMT_W-1:0]  amount = '0;
  logic              done;
  logic [ADDR_W-1:0] readAddr = '0;
  logic [W-1:0]      readData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cyclic_rotator #(.ROT_LEN(R), .WORD_W(W)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .start(start), .amount(amount), .done(done),
    .readAddr(readAddr), .readData(readData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expWord(input logic [R-1:0] v, input int amt, input int j);
    logic [W-1:0] w = '0;
    for (int b = 0; b < W; b++)
      if (j * W + b < R) w[b] = v[(j * W + b + amt) % R];
    return w;
  endfunction

  // Write the vector; padding bits of the last word get junk (R2).
  task automatic loadVec(input logic [R-1:0] v, input logic [W-1:0] junk);
    for (int j = 0; j < NW; j++) begin
      @(negedge clk);
      loadEn = 1'b1;
      loadAddr = ADDR_W'(j);
      for (int b = 0; b < W; b++) loadData[b] = (j * W + b < R) ? v[j * W + b] : junk[b];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Start a rotation and return edges from the accepting edge to done.
  task automatic rotate(input int amt, output int cnt);
    @(negedge clk);
    start = 1'b1;
    amount = AMT_W'(amt);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic checkResult(input logic [R-1:0] v, input int amt, input string req);
    for (int j = 0; j < NW; j++) begin
      readAddr = ADDR_W'(j);
      #0.1;
      check(readData === expWord(v, amt, j), req, int'(readData), int'(expWord(v, amt, j)));
    end
  endtask

  task automatic sweep(input logic [R-1:0] v);
    int cnt;
    loadVec(v, 16'hFFFF);
    for (int a = 0; a < R; a++) begin
      rotate(a, cnt);
      check(cnt == LAT, "R4 latency", cnt, LAT);
      checkResult(v, a, "R3 R5 rotate");
      @(negedge clk);
      check(done === 1'b0, "R4 single pulse", int'(done), 0);
    end
  endtask

  initial begin
    logic [R-1:0] va, vb;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done === 1'b0, "R1 done", int'(done), 0);
    for (int j = 0; j < NW; j++) begin
      readAddr = ADDR_W'(j);
      #0.1;
      check(readData === '0, "R1 result", int'(readData), 0);
    end

    // R3 exhaustive sweeps with several patterns
    va = '0; va[0] = 1'b1;
    sweep(va);
    va = '0; va[R-1] = 1'b1; va[W] = 1'b1;
    sweep(va);
    for (int i = 0; i < R; i++) va[i] = 1'($urandom);
    sweep(va);

    // R2: write to an out-of-range address is dropped
    vb = ~va;
    loadVec(vb, 16'hA5A5);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = ADDR_W'(NW); loadData = 16'hFFFF;
    @(negedge clk);
    loadEn = 1'b0;
    rotate(0, cnt);
    checkResult(vb, 0, "R2 load");
    // R8: out-of-range read is zero; result holds over idle cycles
    readAddr = ADDR_W'(NW);
    #0.1;
    check(readData === '0, "R8 read range", int'(readData), 0);
    repeat (5) @(negedge clk);
    checkResult(vb, 0, "R8 hold");

    // R6: second start mid-run ignored
    @(negedge clk);
    start = 1'b1; amount = AMT_W'(37);
    @(negedge clk);
    amount = AMT_W'(5);
    cnt = 0;
    @(negedge clk);
    cnt++;
    start = 1'b0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == LAT, "R6 latency", cnt, LAT);
    checkResult(vb, 37, "R6 amount");

    // R7: loads during a rotation do not disturb it
    @(negedge clk);
    start = 1'b1; amount = AMT_W'(61);
    @(negedge clk);
    start = 1'b0;
    loadEn = 1'b1; loadAddr = '0; loadData = 16'h1234;
    @(negedge clk);
    loadEn = 1'b0;
    while (!done) @(negedge clk);
    checkResult(vb, 61, "R7 captured");
    va = vb;
    va[W-1:0] = 16'h1234;
    // R9: restart in the done cycle
    start = 1'b1; amount = AMT_W'(23);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == LAT, "R9 restart latency", cnt, LAT);
    checkResult(va, 23, "R7 R9 new data");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule